// File: doc/BRIEF.md
# Round-Robin Bus Arbiter with Grant Parking

This block arbitrates a shared bus among `N` masters. Each master has its own request line and its own grant line. It also has a one-cycle completion strobe that it pulses when its transfer ends. A master may only drive the bus while its grant bit is high. Exactly one grant bit is high at all times. When nothing is pending, the grant stays with the last owner, so that owner can start another transfer at once without arbitrating again.

The choice of the next owner overlaps the running transfer. Every cycle the arbiter looks for the next requester in round-robin order, starting from the index after the current owner. It registers that pick. When the owner pulses completion, the grant moves to the registered pick on that same edge, so no cycle passes without a grant. Two cases can leave an owner holding a parked grant with its own request low. In the first, nothing was pending when it finished. In the second, it never asked for the grant, as with master 0 after reset. If another master then asks, the arbiter withdraws the parked grant and hands it to that requester. An owner that still holds its request high is never pre-empted before it signals completion.

Top module: `park_arb`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, the grant vector is `1` (bit 0 set, master 0 parked).
- R2: In every cycle exactly one bit of the grant vector is high.
- R3: If no master other than the owner is requesting, the grant does not change, even when the owner pulses completion.
- R4: A parked owner (request low) loses its grant when another master requests. The grant moves to that requester on the second rising edge after the request is first sampled, and is unchanged after the first.
- R5: An owner whose request is high and whose completion bit is low keeps its grant in the next cycle, whatever the other masters request.
- R6: When the owner pulses completion and a next owner is already pre-selected, the grant moves on that edge directly to the pre-selected master, with no cycle in which no master is granted.
- R7: The next owner is the first requesting master found by scanning indices owner+1, owner+2, … and wrapping modulo `N`. With all masters requesting, grants therefore rotate 1→2→3→0 for `N`=4.
- R8: A completion pulse from a master that does not hold the grant has no effect on the grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqIn | input | N | Request line per master, bit i for master i |
| doneIn | input | N | Completion strobe per master, one cycle wide |
| gntOut | output | N | One-hot grant, bit i for master i |

## Verification
The properties assume that a requesting master keeps its request high until it is granted. They also assume that a completion bit is a single-cycle pulse. Without the first assumption, a registered pick could name a master that has withdrawn, and the parking and change-of-owner properties would not hold. The directed stimulus changes inputs only just after the falling edge. It holds each request until the grant appears and drops completion after one cycle. It raises no competing request while it is checking parking.

// File: rtl/park_arb_pkg.sv
package park_arb_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic handOver;   // move grant to the registered pick
    logic loadPick;   // refresh the registered pick
  } arbCtl_t;

  // Conditions the datapath reports to control
  typedef struct packed {
    logic ownerReq;   // current owner still requesting
    logic ownerDone;  // current owner pulses completion
    logic pickValid;  // a next owner is pre-selected
  } arbStat_t;

endpackage

// File: rtl/park_arb_pick.sv
module park_arb_pick #(
  parameter int N    = 4,
  parameter int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    reqIn,
  input  logic [IDXW-1:0] ownerIdx,
  output logic            pickValid,
  output logic [IDXW-1:0] pickIdx
);

  localparam int SUMW = IDXW + 1;

  logic [SUMW-1:0] cand;

  // Scan from farthest to nearest so that the nearest hit after the owner wins.
  always_comb begin
    pickValid = 1'b0;
    pickIdx   = ownerIdx;
    cand      = '0;
    for (int off = N - 1; off >= 1; off--) begin
      cand = {1'b0, ownerIdx} + SUMW'(off);
      if (cand >= SUMW'(N)) cand = cand - SUMW'(N);
      if (reqIn[cand[IDXW-1:0]]) begin
        pickValid = 1'b1;
        pickIdx   = cand[IDXW-1:0];
      end
    end
  end

endmodule

// File: rtl/park_arb_dp.sv
module park_arb_dp
  import park_arb_pkg::*;
#(
  parameter int N    = 4,
  parameter int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [N-1:0]    reqIn,
  input  logic [N-1:0]    doneIn,
  input  arbCtl_t         ctl,
  output arbStat_t        stat,
  output logic [N-1:0]    gntOut
);

  logic [IDXW-1:0] ownerQ;
  logic [IDXW-1:0] pickIdxQ;
  logic            pickValidQ;
  logic [IDXW-1:0] pickIdxC;
  logic            pickValidC;

  park_arb_pick #(.N(N), .IDXW(IDXW)) u_pick (
    .reqIn    (reqIn),
    .ownerIdx (ownerQ),
    .pickValid(pickValidC),
    .pickIdx  (pickIdxC)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownerQ     <= '0;
      pickIdxQ   <= '0;
      pickValidQ <= 1'b0;
    end else if (ctl.handOver) begin
      ownerQ     <= pickIdxQ;
      pickValidQ <= 1'b0;   // pick was relative to old owner
    end else if (ctl.loadPick) begin
      pickIdxQ   <= pickIdxC;
      pickValidQ <= pickValidC;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_gnt
    assign gntOut[g] = (ownerQ == IDXW'(g));
  end

  assign stat.ownerReq  = reqIn[ownerQ];
  assign stat.ownerDone = doneIn[ownerQ];
  assign stat.pickValid = pickValidQ;

endmodule

// File: rtl/park_arb_ctl.sv
module park_arb_ctl
  import park_arb_pkg::*;
(
  input  arbStat_t stat,
  output arbCtl_t  ctl
);

  logic releaseNow;

  // Owner finished, or owner is parked with its request low.
  assign releaseNow   = stat.ownerDone || !stat.ownerReq;
  assign ctl.handOver = stat.pickValid && releaseNow;
  assign ctl.loadPick = !ctl.handOver;

endmodule

// File: rtl/park_arb.sv
module park_arb
  import park_arb_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] reqIn,
  input  logic [N-1:0] doneIn,
  output logic [N-1:0] gntOut
);

  localparam int IDXW = (N > 1) ? $clog2(N) : 1;

  arbCtl_t  ctl;
  arbStat_t stat;

  park_arb_dp #(.N(N), .IDXW(IDXW)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .reqIn (reqIn),
    .doneIn(doneIn),
    .ctl   (ctl),
    .stat  (stat),
    .gntOut(gntOut)
  );

  park_arb_ctl u_ctl (
    .stat(stat),
    .ctl (ctl)
  );

endmodule

module park_arb_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rstN,
  input logic [N-1:0] reqIn,
  input logic [N-1:0] doneIn,
  input logic [N-1:0] gntOut
);

  // R1
  reset_park_chk: assert property (@(posedge clk) !rstN |=> (gntOut == N'(1)));

  // R2
  single_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(gntOut) == 1);

  // R3
  park_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((reqIn & ~gntOut) == '0) |=> $stable(gntOut));

  // R5
  active_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (((gntOut & reqIn) != '0) && ((gntOut & doneIn) == '0)) |=> $stable(gntOut));

  // R6
  new_owner_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (gntOut != $past(gntOut)) |-> ((gntOut & $past(reqIn)) != '0));

endmodule

bind park_arb park_arb_chk #(.N(N)) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .reqIn (reqIn),
  .doneIn(doneIn),
  .gntOut(gntOut)
);

// File: tb/park_arb_tb.sv
module park_arb_tb;

  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] reqIn = '0;
  logic [N-1:0] doneIn = '0;
  logic [N-1:0] gntOut;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  park_arb #(.N(N)) u_dut (
    .clk   (clk),
    .rstN  (rstN),
    .reqIn (reqIn),
    .doneIn(doneIn),
    .gntOut(gntOut)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input logic [N-1:0] exp, input string tag);
    checks++;
    if (gntOut !== exp || $countones(gntOut) != 1) begin
      fails++;
      $display("FAIL %s (R2 one-hot also checked): grant actual=%b expected=%b", tag, gntOut, exp);
    end
  endtask

  task automatic t_reset();
    rstN = 1'b0; reqIn = '0; doneIn = '0;
    step(); step();
    check(4'b0001, "R1 during reset");
    rstN = 1'b1;
    step();
    check(4'b0001, "R1 after release");
  endtask

  task automatic t_park();
    reqIn = 4'b0001;
    step(); step(); step();
    doneIn = 4'b0001;
    step();
    doneIn = '0;
    check(4'b0001, "R3 owner done, no rival");
    reqIn = '0;
    step(); step();
    check(4'b0001, "R3 idle parked");
  endtask

  task automatic t_preempt();
    reqIn = 4'b0100;
    step();
    check(4'b0001, "R4 first edge unchanged");
    step();
    check(4'b0100, "R4 second edge taken");
  endtask

  task automatic t_hold();
    reqIn = 4'b1110;
    for (int i = 0; i < 4; i++) begin
      step();
      check(4'b0100, "R5 active owner kept");
    end
  endtask

  task automatic t_foreign_done();
    doneIn = 4'b0010;
    step();
    doneIn = '0;
    step();
    check(4'b0100, "R8 non-owner done ignored");
  endtask

  task automatic t_handover();
    reqIn = 4'b1010; doneIn = 4'b0100;
    step();
    doneIn = '0;
    check(4'b1000, "R6 direct handover to 3");
    step(); step();
    reqIn = 4'b0010; doneIn = 4'b1000;
    step();
    doneIn = '0;
    check(4'b0010, "R7 wrap past 0 to 1");
  endtask

  task automatic t_rotate();
    logic [N-1:0] expSeq [4];
    expSeq[0] = 4'b0100; expSeq[1] = 4'b1000;
    expSeq[2] = 4'b0001; expSeq[3] = 4'b0010;
    reqIn = 4'b1111;
    for (int i = 0; i < 4; i++) begin
      step();
      doneIn = gntOut;
      step();
      doneIn = '0;
      check(expSeq[i], "R7 rotation all requesting");
    end
    reqIn = '0;
  endtask

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
          checks++; fails++;
          $display("FAIL watchdog: actual=timeout expected=completion");
          $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
          $finish;
        end
      end
    join_none
    @(negedge clk);
    t_reset();
    t_park();
    t_preempt();
    t_hold();
    t_foreign_done();
    t_handover();
    t_rotate();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule